// File: doc/BRIEF.md
# Fractional E1 Timeslot Drop and Insert

This block sits beside an E1 framer and serves one link. It counts bit periods from a frame-start pulse to find the current timeslot. It then decides, bit by bit, whether that slot belongs to a fractional channel. On the receive side, each bit of a chosen slot is copied to a serial drop output, and a gapped drop clock pulses once for that bit. On the transmit side, each bit of a chosen slot is taken from a serial insert input under a gapped insert strobe, in place of the framer's normal content.

The normal transmit content is chosen by slot. Slot 0 carries the framer's framing and overhead bit. Slot 16 carries the framer's signaling or datalink bit when either of those generators is enabled. Every other slot carries the PCM bit. Any slot can be chosen for the fractional channel, including slots 0 and 16. An insert into a chosen slot always takes precedence over the framer's content.

A byte-wide register port holds the 32-bit slot mask and the two enables. All datapath outputs are combinational on the current bit, so the block adds no latency to the stream.

Top module: `e1_frac_dropins`

## Requirements
- R1: After reset the slot mask and both enables are 0. Every register reads 0, and neither drop_clk nor ins_strobe pulses.
- R2: Register address k (0 to 3) holds slots 8k to 8k+7, with bit i selecting slot 8k+i. Address 4 holds the receive enable in bit 0 and the transmit enable in bit 1. Written values read back on reg_rdata in the same cycle that reg_addr is presented. Addresses 5 to 7 read 0, and writes to them change nothing.
- R3: A cycle with frame_sync high is bit 0 (the MSB) of slot 0. Each later cycle advances one bit, with 8 bits per slot, so the slot index is count/8. The count wraps from 255 to 0 without a new frame_sync, and a frame_sync in the middle of a frame restarts the count at 0.
- R4: While the receive enable is 1, drop_clk is high in exactly the bit periods of slots whose mask bit is 1. In those periods drop_data equals rx_bit in the same cycle; at all other times drop_data is 0.
- R5: While the receive enable is 0, drop_clk stays low for every slot.
- R6: While the transmit enable is 1, in a slot whose mask bit is 1, ins_strobe is high and tx_out equals ins_bit in the same cycle.
- R7: In payload slots (not 0 or 16) with the mask bit at 0, or with the transmit enable at 0, ins_strobe is low and tx_out equals tx_pcm_bit in the same cycle.
- R8: With no insert active, slot 0 outputs tx_ovh_bit. Slot 16 outputs tx_sig_bit when sig_en or dl_en is 1, and tx_pcm_bit when both are 0.
- R9: A selected slot 0 with the transmit enable at 1 outputs ins_bit in place of tx_ovh_bit.
- R10: A selected slot 16 with the transmit enable at 1 outputs ins_bit for every setting of sig_en and dl_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| frame_sync | input | 1 | Marks bit 0 of slot 0 |
| rx_bit | input | 1 | Framed receive stream |
| drop_clk | output | 1 | One pulse per dropped bit |
| drop_data | output | 1 | Dropped serial data |
| tx_pcm_bit | input | 1 | Transmit PCM bit |
| tx_ovh_bit | input | 1 | Framer framing/overhead bit for slot 0 |
| tx_sig_bit | input | 1 | Framer signaling/datalink bit for slot 16 |
| sig_en | input | 1 | Signaling generator enabled |
| dl_en | input | 1 | Datalink generator enabled |
| ins_bit | input | 1 | Serial insert data |
| ins_strobe | output | 1 | One pulse per inserted bit |
| tx_out | output | 1 | Outgoing transmit stream |

## Verification
The bench runs complete frames under masks that select nothing, everything, only slot 0, only slot 16, and scattered patterns. This catches a design that decodes the slot from the wrong counter bits (the pulses would land one slot off) or that reverses the bit order inside a mask byte. Slot 16 is driven under each combination of sig_en and dl_en. A design that lets the generator enables veto an insert, or that sends PCM while a generator is active, would put the wrong bit on tx_out there. Runs with no frame_sync and with a frame_sync in mid-frame show whether the counter wraps after 256 bits and restarts at once. Writes to the unused addresses and a second reset show any aliasing into the mask or any state that survives reset.

// File: rtl/e1fd_pkg.sv
package e1fd_pkg;
    localparam int DEF_SLOTS     = 32;
    localparam int DEF_SLOT_BITS = 8;
    localparam int CTRL_RX_BIT   = 0;
    localparam int CTRL_TX_BIT   = 1;
    localparam int TS_FRAMING    = 0;
    localparam int TS_SIGNALING  = 16;

    typedef enum logic [1:0] {
        SRC_PCM = 2'd0,
        SRC_OVH = 2'd1,
        SRC_SIG = 2'd2,
        SRC_INS = 2'd3
    } tx_src_e;
endpackage

// File: rtl/e1fd_bit_timer.sv
module e1fd_bit_timer #(
    parameter int NUM_SLOTS = e1fd_pkg::DEF_SLOTS,
    parameter int SLOT_BITS = e1fd_pkg::DEF_SLOT_BITS,
    localparam int TOTAL  = NUM_SLOTS * SLOT_BITS,
    localparam int CNT_W  = $clog2(TOTAL),
    localparam int BIT_W  = $clog2(SLOT_BITS),
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    output logic [SLOT_W-1:0] slot_idx
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t             tmr_d, tmr_q;
    logic [CNT_W-1:0] pos;

    // A sync pulse forces the current bit to position 0 without delay.
    always_comb begin
        tmr_d   = tmr_q;
        pos     = frame_sync ? '0 : tmr_q.cnt;
        tmr_d.cnt = (pos == CNT_W'(TOTAL - 1)) ? '0 : CNT_W'(pos + 1'b1);
        slot_idx  = pos[CNT_W-1:BIT_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assert_sync_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> tmr_q.cnt == CNT_W'(1));
endmodule

// File: rtl/e1fd_cfg_regs.sv
module e1fd_cfg_regs #(
    parameter int NUM_SLOTS = e1fd_pkg::DEF_SLOTS,
    parameter int ADDR_W    = 3,
    localparam int NUM_BYTES = NUM_SLOTS / 8,
    localparam int CTRL_ADDR = NUM_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic [NUM_SLOTS-1:0] slot_mask,
    output logic                 rx_en,
    output logic                 tx_en
);
    import e1fd_pkg::*;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] mask;
        logic                 rx_en;
        logic                 tx_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            for (int b = 0; b < NUM_BYTES; b++) begin
                if (reg_addr == ADDR_W'(b)) cfg_d.mask[b*8 +: 8] = reg_wdata;
            end
            if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
                cfg_d.rx_en = reg_wdata[CTRL_RX_BIT];
                cfg_d.tx_en = reg_wdata[CTRL_TX_BIT];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (reg_addr == ADDR_W'(b)) reg_rdata = cfg_q.mask[b*8 +: 8];
        end
        if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
            reg_rdata[CTRL_RX_BIT] = cfg_q.rx_en;
            reg_rdata[CTRL_TX_BIT] = cfg_q.tx_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign slot_mask = cfg_q.mask;
    assign rx_en     = cfg_q.rx_en;
    assign tx_en     = cfg_q.tx_en;

    assert_low_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == '0) |=> slot_mask[7:0] == $past(reg_wdata));
endmodule

// File: rtl/e1fd_slot_mux.sv
module e1fd_slot_mux #(
    parameter int NUM_SLOTS = e1fd_pkg::DEF_SLOTS,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0] slot_mask,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic                 rx_en,
    input  logic                 tx_en,
    input  logic                 rx_bit,
    input  logic                 tx_pcm_bit,
    input  logic                 tx_ovh_bit,
    input  logic                 tx_sig_bit,
    input  logic                 sig_en,
    input  logic                 dl_en,
    input  logic                 ins_bit,
    output logic                 drop_clk,
    output logic                 drop_data,
    output logic                 ins_strobe,
    output logic                 tx_out
);
    import e1fd_pkg::*;

    logic    slot_sel;
    tx_src_e src;

    always_comb begin
        slot_sel  = slot_mask[slot_idx];
        drop_clk  = rx_en & slot_sel;
        drop_data = drop_clk & rx_bit;

        // Insert wins over every framer source, slot 0 and 16 included.
        if (tx_en && slot_sel)                                      src = SRC_INS;
        else if (slot_idx == SLOT_W'(TS_FRAMING))                   src = SRC_OVH;
        else if (slot_idx == SLOT_W'(TS_SIGNALING) && (sig_en || dl_en)) src = SRC_SIG;
        else                                                        src = SRC_PCM;

        ins_strobe = (src == SRC_INS);
        unique case (src)
            SRC_INS: tx_out = ins_bit;
            SRC_OVH: tx_out = tx_ovh_bit;
            SRC_SIG: tx_out = tx_sig_bit;
            default: tx_out = tx_pcm_bit;
        endcase
    end
endmodule

// File: rtl/e1_frac_dropins.sv
module e1_frac_dropins #(
    parameter int NUM_SLOTS = e1fd_pkg::DEF_SLOTS,
    parameter int SLOT_BITS = e1fd_pkg::DEF_SLOT_BITS,
    parameter int ADDR_W    = 3,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              frame_sync,
    input  logic              rx_bit,
    output logic              drop_clk,
    output logic              drop_data,
    input  logic              tx_pcm_bit,
    input  logic              tx_ovh_bit,
    input  logic              tx_sig_bit,
    input  logic              sig_en,
    input  logic              dl_en,
    input  logic              ins_bit,
    output logic              ins_strobe,
    output logic              tx_out
);
    logic [NUM_SLOTS-1:0] mask_w;
    logic                 rx_en_w, tx_en_w;
    logic [SLOT_W-1:0]    slot_w;

    e1fd_bit_timer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_idx(slot_w)
    );

    e1fd_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slot_mask(mask_w),
        .rx_en(rx_en_w), .tx_en(tx_en_w)
    );

    e1fd_slot_mux #(.NUM_SLOTS(NUM_SLOTS)) u_mux (
        .slot_mask(mask_w), .slot_idx(slot_w), .rx_en(rx_en_w), .tx_en(tx_en_w),
        .rx_bit(rx_bit), .tx_pcm_bit(tx_pcm_bit), .tx_ovh_bit(tx_ovh_bit),
        .tx_sig_bit(tx_sig_bit), .sig_en(sig_en), .dl_en(dl_en), .ins_bit(ins_bit),
        .drop_clk(drop_clk), .drop_data(drop_data), .ins_strobe(ins_strobe),
        .tx_out(tx_out)
    );

    assert_drop_in_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        drop_clk |-> mask_w[slot_w]);
    assert_drop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_clk |-> !drop_data);
    assert_rx_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_w |-> !drop_clk);
    assert_insert_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_strobe |-> (tx_out == ins_bit && tx_en_w));
    assert_ts0_framer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_w == '0 && !ins_strobe) |-> tx_out == tx_ovh_bit);
endmodule

// File: tb/sim_e1_frac_dropins.sv
module sim_e1_frac_dropins;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_we;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       frame_sync, rx_bit, drop_clk, drop_data;
    logic       tx_pcm_bit, tx_ovh_bit, tx_sig_bit, sig_en, dl_en, ins_bit;
    logic       ins_strobe, tx_out;

    always #5 clk = ~clk;

    e1_frac_dropins u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_sync(frame_sync),
        .rx_bit(rx_bit), .drop_clk(drop_clk), .drop_data(drop_data),
        .tx_pcm_bit(tx_pcm_bit), .tx_ovh_bit(tx_ovh_bit), .tx_sig_bit(tx_sig_bit),
        .sig_en(sig_en), .dl_en(dl_en), .ins_bit(ins_bit),
        .ins_strobe(ins_strobe), .tx_out(tx_out)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;
    logic [7:0]  m_cnt;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] c_mask = '0;
    logic        c_rx = 1'b0, c_tx = 1'b0;

    // Mask [35:4], rx enable [3], tx enable [2], sig_en [1], dl_en [0]
    localparam logic [35:0] VEC [8] = '{
        {32'h0000_0000, 4'b1100},
        {32'hFFFF_FFFF, 4'b1100},
        {32'h0000_0001, 4'b0110},
        {32'h0001_0000, 4'b1110},
        {32'h0001_0000, 4'b0101},
        {32'hA5A5_0F0F, 4'b1000},
        {32'h8000_0002, 4'b0100},
        {32'h0000_0000, 4'b0011}
    };

    // Bench bit position per the frame timing rule (R3)
    always @(posedge clk) begin
        if (!rst_n) m_cnt <= 8'd0;
        else        m_cnt <= frame_sync ? 8'd1 : m_cnt + 8'd1;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        frame_sync = 1'b0;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
        if (a < 3'd4) c_mask[a*8 +: 8] = d;
        else if (a == 3'd4) begin c_rx = d[0]; c_tx = d[1]; end
    endtask

    task automatic reg_rd_chk(logic [2:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        frame_sync = 1'b0;
        reg_addr = a;
        #2 chk(req, $sformatf("read addr %0d", a), {24'd0, reg_rdata}, {24'd0, exp});
    endtask

    task automatic run_cycles(int n, int sync_at, string ctx);
        for (int i = 0; i < n; i++) begin
            logic [7:0] pos;
            logic [4:0] ts;
            logic       sel, e_dclk, e_ddat, e_stb, e_tx;
            string      rtag, ttag;
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            frame_sync = (i == sync_at);
            rx_bit = lfsr[0]; tx_pcm_bit = lfsr[3]; tx_ovh_bit = lfsr[6];
            tx_sig_bit = lfsr[9]; ins_bit = lfsr[12];
            #2;
            pos    = frame_sync ? 8'd0 : m_cnt;
            ts     = pos[7:3];
            sel    = c_mask[ts];
            e_dclk = c_rx & sel;
            e_ddat = e_dclk & rx_bit;
            e_stb  = c_tx & sel;
            if (e_stb)                                e_tx = ins_bit;
            else if (ts == 5'd0)                      e_tx = tx_ovh_bit;
            else if (ts == 5'd16 && (sig_en | dl_en)) e_tx = tx_sig_bit;
            else                                      e_tx = tx_pcm_bit;
            rtag = c_rx ? "R4" : "R5";
            if (e_stb) ttag = (ts == 5'd0) ? "R9" : ((ts == 5'd16) ? "R10" : "R6");
            else       ttag = (ts == 5'd0 || ts == 5'd16) ? "R8" : "R7";
            if (ctx != "") begin rtag = {ctx, "/", rtag}; ttag = {ctx, "/", ttag}; end
            chk(rtag, $sformatf("drop_clk ts%0d", ts), {31'd0, drop_clk}, {31'd0, e_dclk});
            chk(rtag, $sformatf("drop_data ts%0d", ts), {31'd0, drop_data}, {31'd0, e_ddat});
            chk(ttag, $sformatf("ins_strobe ts%0d", ts), {31'd0, ins_strobe}, {31'd0, e_stb});
            chk(ttag, $sformatf("tx_out ts%0d", ts), {31'd0, tx_out}, {31'd0, e_tx});
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        c_mask = '0; c_rx = 1'b0; c_tx = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        frame_sync = 1'b0; rx_bit = 1'b0; tx_pcm_bit = 1'b0; tx_ovh_bit = 1'b0;
        tx_sig_bit = 1'b0; sig_en = 1'b1; dl_en = 1'b1; ins_bit = 1'b0;
        do_reset();

        // R1: registers clear and no strobes after reset
        for (int a = 0; a < 5; a++) reg_rd_chk(3'(a), 8'h00, "R1");
        run_cycles(64, 0, "R1");

        // Table of configurations, one full frame each
        for (int v = 0; v < 8; v++) begin
            for (int b = 0; b < 4; b++) reg_wr(3'(b), VEC[v][4 + b*8 +: 8]);
            reg_wr(3'd4, {6'd0, VEC[v][2], VEC[v][3]});
            sig_en = VEC[v][1]; dl_en = VEC[v][0];
            for (int b = 0; b < 4; b++) reg_rd_chk(3'(b), VEC[v][4 + b*8 +: 8], "R2");
            reg_rd_chk(3'd4, {6'd0, VEC[v][2], VEC[v][3]}, "R2");
            run_cycles(256, 0, "");
        end

        // R3: wrap without sync, then a mid-frame resync
        reg_wr(3'd0, 8'h20); reg_wr(3'd1, 8'h00); reg_wr(3'd2, 8'h01);
        reg_wr(3'd3, 8'h80); reg_wr(3'd4, 8'h03);
        sig_en = 1'b0; dl_en = 1'b0;
        run_cycles(256, 0, "R3");
        run_cycles(300, -1, "R3");
        run_cycles(200, 77, "R3");

        // R2: unused addresses read 0 and do not alias
        reg_wr(3'd5, 8'hFF); reg_wr(3'd6, 8'hFF); reg_wr(3'd7, 8'hFF);
        reg_rd_chk(3'd5, 8'h00, "R2");
        reg_rd_chk(3'd7, 8'h00, "R2");
        reg_rd_chk(3'd0, 8'h20, "R2");
        reg_rd_chk(3'd2, 8'h01, "R2");
        reg_rd_chk(3'd3, 8'h80, "R2");
        reg_rd_chk(3'd4, 8'h03, "R2");
        run_cycles(256, 0, "R2");

        // R10: slot 16 insert with both generator enables on
        sig_en = 1'b1; dl_en = 1'b1;
        run_cycles(256, 0, "R10");

        // R1: a second reset clears the loaded state
        do_reset();
        for (int a = 0; a < 5; a++) reg_rd_chk(3'(a), 8'h00, "R1");
        run_cycles(256, 0, "R1");

        finish_run();
    end
endmodule